// File: doc/BRIEF.md
# Fractional Sample-Clock Resampler

This block takes a complex baseband stream (separate I and Q words) whose sample clock runs slightly fast or slow against the transmitter, and resamples it so that the stream again carries the nominal number of samples per unit of signal time. A signed slope word gives the timing drift per input sample as a fraction of one sample. That slope is added into an unsigned fractional delay on every accepted input. The delay steers one cubic Farrow interpolator per lane, and both lanes use the same delay value.

The delay always stays in [0,1). When adding the slope would carry the delay past 1.0, the delay wraps and the output for that input is thrown away. When adding the slope would take the delay below 0, the delay wraps upward and one extra output is inserted. The extra output is the unfiltered sample at zero delay, and it is emitted before the interpolated one. To make room for it, input ready drops for one cycle. No rate-change stages are used, and the delay may change on every sample.

The slope comes from a separate timing-drift estimator, and the output feeds the symbol timing and FFT stages.

Top module: `frac_resampler`

## Requirements
- R1: After reset, out_valid_o is 0, in_ready_o is 1 and the fractional delay is 0.
- R2: An input is accepted on a clock edge where in_valid_i and in_ready_o are both 1. The first three accepted samples only fill the four-tap history. From the fourth accepted sample on, each accepted sample gives at most one interpolated output, registered one cycle after acceptance, except in the R5 case.
- R3: The delay mu is an FW-bit unsigned fraction, with 2^FW meaning 1.0. On every accepted sample, mu becomes mu + slope_i. With newest sample x[n], the interpolated output is the cubic Lagrange fit through x[n-3..n] evaluated at position n-2+mu, to within 2 LSB. This value is x[n-2] when mu is 0.
- R4: If mu + slope is 1.0 or more, mu wraps by subtracting 1.0 and no output is produced for that sample.
- R5: If mu + slope is below 0, mu wraps by adding 1.0 and two outputs follow in consecutive cycles. The first is x[n-2], passed unfiltered. The second is the interpolation at the wrapped mu. in_ready_o is 0 for exactly the one cycle between them.
- R6: With slope 0, mu does not change. With mu equal to 0, the output equals the input delayed by two samples, exactly.
- R7: Interpolated results are rounded and saturated to the signed DW-bit range.
- R8: The I and Q lanes use the same delay and the same wrap events, and their data do not mix.
- R9: A cycle with in_valid_i low shifts no history, leaves mu unchanged and produces no new output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample present |
| in_ready_o | output | 1 | Input can be accepted (low for one cycle on an inserted beat) |
| in_i_i | input | DW | In-phase input sample, signed |
| in_q_i | input | DW | Quadrature input sample, signed |
| slope_i | input | SW | Signed delay increment per accepted sample, FW fraction bits |
| out_valid_o | output | 1 | Output sample present |
| out_i_o | output | DW | Resampled in-phase sample, signed |
| out_q_o | output | DW | Resampled quadrature sample, signed |

## Verification
The hardest case to reach is an inserted beat that arrives while the source keeps in_valid_i high, so that the stall overlaps a pending input and the beat order must still hold. The stimulus gets there with a slope of -0.5. At that slope the delay underflows on every other sample, so the driver repeatedly meets in_ready_o low in the middle of a burst. A scoreboard pushes the unfiltered beat ahead of the interpolated one and checks that order. Drops are driven by large positive slopes on ramps, and saturation by a +/- full-scale pattern whose cubic fit overshoots for every nonzero delay.

// File: rtl/frs_pkg.sv
package frs_pkg;
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_DROP = 2'd1,
    EV_REP  = 2'd2
  } wrap_ev_e;
endpackage

// File: rtl/delay_accum.sv
module delay_accum
  import frs_pkg::*;
#(
  parameter int FW = 16,
  parameter int SW = 16  // must not exceed FW+1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 step_i,
  input  logic signed [SW-1:0] slope_i,
  output logic        [FW-1:0] mu_o,
  output wrap_ev_e             ev_o
);
  localparam int AW = FW + 2;

  logic signed [AW-1:0] sum;
  wrap_ev_e             ev_d;

  always_comb begin
    sum = $signed({2'b00, mu_o}) + AW'(slope_i);
    if (sum[AW-1])      ev_d = EV_REP;
    else if (sum[FW])   ev_d = EV_DROP;
    else                ev_d = EV_NONE;
  end

  // wrap by +/-1.0 is just dropping the integer bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mu_o <= '0;
      ev_o <= EV_NONE;
    end else if (step_i) begin
      mu_o <= sum[FW-1:0];
      ev_o <= ev_d;
    end
  end

  a_r4_no_drop_nonpos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && slope_i <= 0) |=> ev_o != EV_DROP);
  a_r5_no_rep_nonneg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && slope_i >= 0) |=> ev_o != EV_REP);
  a_r6_zero_slope_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && slope_i == 0) |=> mu_o == $past(mu_o));
  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> ($stable(mu_o) && $stable(ev_o)));
endmodule

// File: rtl/farrow_cubic.sv
module farrow_cubic #(
  parameter int DW = 16,
  parameter int FW = 16
) (
  input  logic signed [DW-1:0] taps_i [4],  // [0] newest
  input  logic        [FW-1:0] mu_i,
  output logic signed [DW-1:0] y_o
);
  localparam int KW   = DW + 6;
  localparam int PW   = KW + FW + 1;
  localparam int RW   = 20;
  localparam int FULL = PW + RW + 2;
  localparam logic signed [RW+1:0] RECIP6 = (RW+2)'(((1 << RW) + 3) / 6);
  localparam logic signed [KW-1:0] YMAX = KW'((2 ** (DW - 1)) - 1);
  localparam logic signed [KW-1:0] YMIN = KW'(-(2 ** (DW - 1)));

  logic signed [KW-1:0]   xm1, x0, xp1, xp2;
  logic signed [KW-1:0]   k1, k2, k3, h2, h1, frac, ysum;
  logic signed [FW:0]     t;
  logic signed [PW-1:0]   p3, p2, p1;
  logic signed [FULL-1:0] qf;

  // coefficients scaled by 6; Horner in t, then one multiply by 1/6
  always_comb begin
    xm1  = KW'(taps_i[3]);
    x0   = KW'(taps_i[2]);
    xp1  = KW'(taps_i[1]);
    xp2  = KW'(taps_i[0]);
    k1   = KW'(6) * xp1 - KW'(3) * x0 - (xm1 <<< 1) - xp2;
    k2   = KW'(3) * (xm1 + xp1) - KW'(6) * x0;
    k3   = (xp2 - xm1) + KW'(3) * (x0 - xp1);
    t    = $signed({1'b0, mu_i});
    p3   = PW'(t) * PW'(k3);
    h2   = k2 + KW'(p3 >>> FW);
    p2   = PW'(t) * PW'(h2);
    h1   = k1 + KW'(p2 >>> FW);
    p1   = PW'(t) * PW'(h1);
    qf   = FULL'(p1) * FULL'(RECIP6) + (FULL'(1) <<< (FW + RW - 1));
    frac = KW'(qf >>> (FW + RW));
    ysum = x0 + frac;
    if (ysum > YMAX)      y_o = DW'(YMAX);
    else if (ysum < YMIN) y_o = DW'(YMIN);
    else                  y_o = DW'(ysum);
  end

  always_comb begin
    if (mu_i == '0) a_r6_zero_mu_passthru: assert (y_o == taps_i[2]);
  end
endmodule

// File: rtl/frac_resampler.sv
module frac_resampler
  import frs_pkg::*;
#(
  parameter int DW = 16,
  parameter int FW = 16,
  parameter int SW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic signed [DW-1:0] in_i_i,
  input  logic signed [DW-1:0] in_q_i,
  input  logic signed [SW-1:0] slope_i,
  output logic                 out_valid_o,
  output logic signed [DW-1:0] out_i_o,
  output logic signed [DW-1:0] out_q_o
);
  localparam int          LANES     = 2;
  localparam int          NTAP      = 4;
  localparam logic [1:0]  FILL_LAST = 2'(NTAP - 1);

  logic                 accept, rep_first;
  logic [FW-1:0]        mu_q;
  wrap_ev_e             ev_q;
  logic [1:0]           fill_q;
  logic                 st_vld_q, rep_done_q;
  logic signed [DW-1:0] lane_in  [LANES];
  logic signed [DW-1:0] lane_y   [LANES];
  logic signed [DW-1:0] lane_bp  [LANES];
  logic signed [DW-1:0] lane_out_q [LANES];

  assign lane_in[0] = in_i_i;
  assign lane_in[1] = in_q_i;

  assign rep_first  = st_vld_q && (ev_q == EV_REP) && !rep_done_q;
  assign in_ready_o = !rep_first;
  assign accept     = in_valid_i && in_ready_o;

  delay_accum #(.FW(FW), .SW(SW)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (accept),
    .slope_i(slope_i),
    .mu_o   (mu_q),
    .ev_o   (ev_q)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [DW-1:0] tap_q [NTAP];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int k = 0; k < NTAP; k++) tap_q[k] <= '0;
      end else if (accept) begin
        tap_q[0] <= lane_in[g];
        for (int k = 1; k < NTAP; k++) tap_q[k] <= tap_q[k-1];
      end
    end

    farrow_cubic #(.DW(DW), .FW(FW)) u_fir (
      .taps_i(tap_q),
      .mu_i  (mu_q),
      .y_o   (lane_y[g])
    );

    assign lane_bp[g] = tap_q[2];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q     <= '0;
      st_vld_q   <= 1'b0;
      rep_done_q <= 1'b0;
    end else begin
      if (accept && fill_q != FILL_LAST) fill_q <= fill_q + 2'd1;
      if (accept)        st_vld_q <= (fill_q == FILL_LAST);
      else if (st_vld_q && !rep_first) st_vld_q <= 1'b0;
      if (accept)         rep_done_q <= 1'b0;
      else if (rep_first) rep_done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      for (int l = 0; l < LANES; l++) lane_out_q[l] <= '0;
    end else if (rep_first) begin
      out_valid_o <= 1'b1;
      for (int l = 0; l < LANES; l++) lane_out_q[l] <= lane_bp[l];
    end else if (st_vld_q) begin
      out_valid_o <= (ev_q != EV_DROP);
      for (int l = 0; l < LANES; l++) lane_out_q[l] <= lane_y[l];
    end else begin
      out_valid_o <= 1'b0;
    end
  end

  assign out_i_o = lane_out_q[0];
  assign out_q_o = lane_out_q[1];

  a_r5_stall_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |=> in_ready_o);
  a_r5_stall_emits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |=> out_valid_o);
  a_r2_out_needs_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(st_vld_q));
  a_r9_idle_no_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_valid_i && !st_vld_q) |=> !st_vld_q);
endmodule

// File: tb/sim_frac_resampler.sv
module sim_frac_resampler;
  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               in_valid_i = 1'b0;
  logic               in_ready_o;
  logic signed [15:0] in_i_i = '0;
  logic signed [15:0] in_q_i = '0;
  logic signed [15:0] slope_i = '0;
  logic               out_valid_o;
  logic signed [15:0] out_i_o, out_q_o;

  always #10 clk_i = ~clk_i;

  frac_resampler u0 (.*);

  typedef struct {
    int    i;
    int    q;
    int    tol;
    string req;
  } exp_t;

  exp_t sbq[$];
  int   checks = 0, errors = 0;
  int   mu_m = 0, nacc = 0, drops = 0, reps = 0;
  int   hi[4] = '{0, 0, 0, 0};
  int   hq[4] = '{0, 0, 0, 0};
  bit   done = 0;

  function automatic int lagr(real t, int x3, int x2, int x1, int x0);
    real y;
    int  r;
    y = -t * (t - 1.0) * (t - 2.0) / 6.0 * x3
        + (t + 1.0) * (t - 1.0) * (t - 2.0) / 2.0 * x2
        - (t + 1.0) * t * (t - 2.0) / 2.0 * x1
        + (t + 1.0) * t * (t - 1.0) / 6.0 * x0;
    r = $rtoi($floor(y + 0.5));
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic model_accept(input int xi, input int xq, input int sl, input string req);
    exp_t e;
    int   s;
    for (int k = 3; k > 0; k--) begin hi[k] = hi[k-1]; hq[k] = hq[k-1]; end
    hi[0] = xi; hq[0] = xq;
    nacc++;
    s = mu_m + sl;
    if (s >= 65536) begin
      mu_m = s - 65536;
      if (nacc >= 4) drops++;
      return;
    end
    if (s < 0) begin
      mu_m = s + 65536;
      if (nacc >= 4) begin
        reps++;
        e.i = hi[2]; e.q = hq[2]; e.tol = 0; e.req = "R5";
        sbq.push_back(e);
      end
    end else begin
      mu_m = s;
    end
    if (nacc >= 4) begin
      e.i = lagr(real'(mu_m) / 65536.0, hi[3], hi[2], hi[1], hi[0]);
      e.q = lagr(real'(mu_m) / 65536.0, hq[3], hq[2], hq[1], hq[0]);
      e.tol = (mu_m == 0) ? 0 : 2;
      e.req = req;
      sbq.push_back(e);
    end
  endtask

  task automatic send(input int xi, input int xq, input int sl, input string req);
    @(negedge clk_i);
    in_valid_i = 1'b1;
    in_i_i     = 16'(xi);
    in_q_i     = 16'(xq);
    slope_i    = 16'(sl);
    while (!in_ready_o) @(negedge clk_i);
    model_accept(xi, xq, sl, req);
    @(posedge clk_i);
  endtask

  task automatic idle(input int n);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && out_valid_o && !done) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R2 unexpected output", int'(out_i_o), 0);
      end else begin
        exp_t e;
        int di, dq;
        e  = sbq.pop_front();
        di = int'(out_i_o) - e.i;
        dq = int'(out_q_o) - e.q;
        if (di < 0) di = -di;
        if (dq < 0) dq = -dq;
        check(di <= e.tol, {e.req, " I lane"}, int'(out_i_o), e.i);
        check(dq <= e.tol, {e.req, " Q lane R8"}, int'(out_q_o), e.q);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    check(1'b0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(out_valid_o == 1'b0, "R1 out_valid in reset", int'(out_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(out_valid_o == 1'b0, "R1 out_valid after reset", int'(out_valid_o), 0);
    check(in_ready_o == 1'b1, "R1 in_ready after reset", int'(in_ready_o), 1);

    // R6: zero slope, mu stays 0 -> exact two-sample delay
    for (int n = 0; n < 10; n++) send(100 * n, -50 * n, 0, "R6");
    idle(3);
    check(sbq.size() == 0, "R2 all outputs seen", sbq.size(), 0);

    // R3/R4: positive drift on a ramp, with idle gaps (R9)
    for (int n = 0; n < 30; n++) begin
      send(200 * n - 3000, 7000 - 150 * n, 6144, "R3");
      if (n % 7 == 3) idle(3);
    end
    // R4: largest positive slope
    for (int n = 0; n < 12; n++) send(300 * n, -300 * n, 32767, "R4");

    // R5: negative drift, then the most negative slope
    for (int n = 0; n < 30; n++) send(250 * n - 4000, 90 * n, -8192, "R5");
    for (int n = 0; n < 16; n++) send(-500 * n + 4000, 400 * n, -32768, "R5");
    idle(2);

    // R3: cubic signal, fit is exact for cubics
    for (int n = 0; n <= 40; n++)
      send(3 * (n - 20) * (n - 20) * (n - 20), 10 * n * n - 8000, 1792, "R3");

    // R7: full-scale pattern overshoots the range
    for (int r = 0; r < 2; r++) begin
      send(-32768, 32767, 0, "R7");
      send(32767, -32768, 0, "R7");
      send(32767, -32768, 0, "R7");
      send(-32768, 32767, 0, "R7");
      send(-32768, 32767, 0, "R7");
      send(32767, -32768, 0, "R7");
    end
    idle(3);
    send(-32768, -32768, 5000, "R7");
    send(32767, 32767, 0, "R7");
    send(32767, 32767, 0, "R7");
    send(-32768, -32768, 0, "R7");

    idle(6);
    check(sbq.size() == 0, "R4/R5 output count matches model", sbq.size(), 0);
    check(drops > 0, "R4 drops exercised", drops, 1);
    check(reps > 0, "R5 repeats exercised", reps, 1);
    check(out_valid_o == 1'b0, "R9 no output while idle", int'(out_valid_o), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule